// File: doc/BRIEF.md
# Dual-Lane Fractional Multiply-Accumulate Unit

This block is a two-lane arithmetic execution unit for fixed-point filter kernels. Each lane accepts one request per clock. A request carries a two-bit operation code, a rounding flag, a 64-bit addend `in_acc`, two 64-bit multiplicand words `in_opa` and `in_opb`, and a 6-bit shift count. Four operations are available. The scalar fractional multiply-add keeps the integer part of a Q31 product. The packed form applies the same step independently in each 32-bit half. The dot product multiplies two signed 32-bit pairs and adds both products to a 64-bit addend. The arithmetic right shift of the addend can round to nearest.

The two lanes are identical and fully independent. A caller that needs two streams in parallel, such as two filter taps or two output bands, can issue to both lanes in the same cycle. Each lane is a fixed two-stage pipeline. Its output has a valid flag that follows the request valid flag. All arithmetic wraps on overflow and nothing saturates.

Top module: `dual_mac_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every `out_vld` bit and every `out_res` word is cleared to zero.
- R2: Opcode 2'b00 (fractional multiply-add) returns `in_acc + ((opa[31:0] * opb[31:0]) >>> 31)`. The product is a signed 64-bit value and the sum wraps at 64 bits. Bits [63:32] of both multiplicands have no effect.
- R3: Opcode 2'b01 (packed multiply-add) computes each 32-bit half h (h = 0 for bits [31:0], h = 1 for bits [63:32]) as `acc_h + low 32 bits of ((opa_h * opb_h) >>> 31)`. Each half wraps at 32 bits and no carry crosses between the halves.
- R4: Opcode 2'b10 (dot product) returns `in_acc + opa[63:32]*opb[63:32] + opa[31:0]*opb[31:0]`, with all four halves taken as signed. The sum wraps at 64 bits.
- R5: Opcode 2'b11 (shift) with a nonzero count s returns `in_acc` shifted arithmetically right by s. If `in_rnd` is 1, it adds 2^(s-1) first, computed with a guard bit so that the addition cannot overflow. `in_rnd` has no effect on opcodes 00, 01 and 10.
- R6: Opcode 2'b11 with a shift count of 0 returns `in_acc` unchanged, whatever the value of `in_rnd`.
- R7: A request sampled with `in_vld` high at rising edge E sets `out_vld` high after edge E+1, for exactly one cycle. `out_res` carries that request's result in the same cycle. A request with `in_vld` low produces no `out_vld`.
- R8: `out_res` keeps its last result in every cycle in which `out_vld` is low.
- R9: Requests given to lane 0 and lane 1 in the same cycle both complete in the same later cycle. Each lane's result depends only on its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | NUM_LANES | Request valid, one bit per lane |
| in_op | input | NUM_LANES x 2 | Operation code per lane (00 mac, 01 packed mac, 10 dot, 11 shift) |
| in_rnd | input | NUM_LANES | Round-to-nearest enable for the shift |
| in_acc | input | NUM_LANES x 64 | Addend, or the operand of the shift |
| in_opa | input | NUM_LANES x 64 | First multiplicand word (two signed 32-bit halves) |
| in_opb | input | NUM_LANES x 64 | Second multiplicand word (two signed 32-bit halves) |
| in_shamt | input | NUM_LANES x 6 | Arithmetic right shift count, 0 to 63 |
| out_vld | output | NUM_LANES | Result valid per lane |
| out_res | output | NUM_LANES x 64 | Result per lane |

## Verification
The embedded properties assume that a request's operation code, shift count and operands are stable and known during the cycle in which `in_vld` is high. They also assume that `rst_n` is held low for at least one edge before the first request. The stimulus drives every input only on the falling clock edge. It keeps unused fields at defined values and asserts reset for three edges before any traffic. The stimulus places boundary operands (most negative halves, all ones, shift counts 0, 1 and 63, addends at the 64-bit limit) on both lanes in the same cycle. Random traffic then runs with idle gaps, so that the hold behaviour of R8 is exercised as well.

// File: rtl/dmac_pkg.sv
// Package: shared operation encoding for the dual-lane MAC unit.
// Assumes two-bit opcodes; the encoding is part of the block interface.
package dmac_pkg;

    typedef enum logic [1:0] {
        OP_MAC  = 2'b00,   // fractional multiply-add, lower halves only
        OP_PMAC = 2'b01,   // two independent 32-bit fractional multiply-adds
        OP_DOT  = 2'b10,   // two-element dot product plus 64-bit addend
        OP_SHR  = 2'b11    // arithmetic right shift with optional rounding
    } dmac_op_e;

endpackage

// File: rtl/dmac_mul_pair.sv
// Module: dmac_mul_pair
// Forms the two signed products of the lower and the upper halves of
// two packed words. Purely combinational; the caller registers the
// results. Assumes each half is a two's complement value.
module dmac_mul_pair #(
    parameter  int HALF_W = 32,
    localparam int PROD_W = 2 * HALF_W
) (
    input  logic [PROD_W-1:0]        word_a,
    input  logic [PROD_W-1:0]        word_b,
    output logic signed [PROD_W-1:0] prod_lo,
    output logic signed [PROD_W-1:0] prod_hi
);

    logic signed [PROD_W-1:0] a_lo_x, a_hi_x, b_lo_x, b_hi_x;

    // Sign-extend every half to the full product width.
    always_comb begin
        a_lo_x = {{HALF_W{word_a[HALF_W-1]}}, word_a[HALF_W-1:0]};
        a_hi_x = {{HALF_W{word_a[PROD_W-1]}}, word_a[PROD_W-1:HALF_W]};
        b_lo_x = {{HALF_W{word_b[HALF_W-1]}}, word_b[HALF_W-1:0]};
        b_hi_x = {{HALF_W{word_b[PROD_W-1]}}, word_b[PROD_W-1:HALF_W]};
    end

    // Two full-width signed multiplies; the product of two halves fits.
    always_comb begin
        prod_lo = a_lo_x * b_lo_x;
        prod_hi = a_hi_x * b_hi_x;
    end

endmodule

// File: rtl/dmac_combine.sv
// Module: dmac_combine
// Second-stage arithmetic: scales products and adds the addend, or
// shifts the addend. Purely combinational. Assumes the products come
// from dmac_mul_pair and that all sums wrap without saturation.
module dmac_combine
    import dmac_pkg::*;
#(
    parameter  int HALF_W  = 32,
    parameter  int SHAMT_W = 6,
    parameter  int FRAC_SH = 31,
    localparam int DATA_W  = 2 * HALF_W
) (
    input  dmac_op_e                 op,
    input  logic                     rnd,
    input  logic [SHAMT_W-1:0]       shamt,
    input  logic signed [DATA_W-1:0] acc,
    input  logic signed [DATA_W-1:0] prod_lo,
    input  logic signed [DATA_W-1:0] prod_hi,
    output logic [DATA_W-1:0]        res
);

    logic signed [DATA_W-1:0] lo_scaled;
    logic signed [DATA_W:0]   guard_ext;
    logic signed [DATA_W:0]   half_lsb;

    // Scaled lower product and the guarded rounding sum for the shift.
    always_comb begin
        lo_scaled = prod_lo >>> FRAC_SH;
        half_lsb  = (DATA_W+1)'(1) <<< (shamt - SHAMT_W'(1));
        guard_ext = {acc[DATA_W-1], acc} + half_lsb;
    end

    // Select the operation result.
    always_comb begin
        res = acc;
        case (op)
            OP_MAC:  res = acc + lo_scaled;
            OP_PMAC: begin
                res[HALF_W-1:0]      = acc[HALF_W-1:0] + lo_scaled[HALF_W-1:0];
                res[DATA_W-1:HALF_W] = acc[DATA_W-1:HALF_W]
                                       + HALF_W'(prod_hi >>> FRAC_SH);
            end
            OP_DOT:  res = acc + prod_lo + prod_hi;
            OP_SHR: begin
                if (shamt == '0)
                    res = acc;
                else if (rnd)
                    res = DATA_W'(guard_ext >>> shamt);
                else
                    res = acc >>> shamt;
            end
            default: res = acc;
        endcase
    end

endmodule

// File: rtl/dmac_lane.sv
// Module: dmac_lane
// One execution lane: stage 1 registers the products and the request,
// stage 2 registers the combined result. Fixed two-edge latency, one
// request per cycle. Assumes synchronous active-low reset.
module dmac_lane
    import dmac_pkg::*;
#(
    parameter  int HALF_W  = 32,
    parameter  int SHAMT_W = 6,
    parameter  int FRAC_SH = 31,
    localparam int DATA_W  = 2 * HALF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld,
    input  logic [1:0]         in_op,
    input  logic               in_rnd,
    input  logic [DATA_W-1:0]  in_acc,
    input  logic [DATA_W-1:0]  in_opa,
    input  logic [DATA_W-1:0]  in_opb,
    input  logic [SHAMT_W-1:0] in_shamt,
    output logic               out_vld,
    output logic [DATA_W-1:0]  out_res
);

    logic signed [DATA_W-1:0] mul_lo, mul_hi;
    logic                     s1_vld;
    dmac_op_e                 s1_op;
    logic                     s1_rnd;
    logic [SHAMT_W-1:0]       s1_shamt;
    logic signed [DATA_W-1:0] s1_acc, s1_plo, s1_phi;
    logic [DATA_W-1:0]        comb_res;

    dmac_mul_pair #(.HALF_W(HALF_W)) mul_i (
        .word_a (in_opa),
        .word_b (in_opb),
        .prod_lo(mul_lo),
        .prod_hi(mul_hi)
    );

    // Stage 1: capture the request and both products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_op    <= OP_MAC;
            s1_rnd   <= 1'b0;
            s1_shamt <= '0;
            s1_acc   <= '0;
            s1_plo   <= '0;
            s1_phi   <= '0;
        end else begin
            s1_vld <= in_vld;
            if (in_vld) begin
                s1_op    <= dmac_op_e'(in_op);
                s1_rnd   <= in_rnd;
                s1_shamt <= in_shamt;
                s1_acc   <= in_acc;
                s1_plo   <= mul_lo;
                s1_phi   <= mul_hi;
            end
        end
    end

    dmac_combine #(
        .HALF_W (HALF_W),
        .SHAMT_W(SHAMT_W),
        .FRAC_SH(FRAC_SH)
    ) comb_i (
        .op     (s1_op),
        .rnd    (s1_rnd),
        .shamt  (s1_shamt),
        .acc    (s1_acc),
        .prod_lo(s1_plo),
        .prod_hi(s1_phi),
        .res    (comb_res)
    );

    // Stage 2: register the result; keep it while no request completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_res <= '0;
        end else begin
            out_vld <= s1_vld;
            if (s1_vld)
                out_res <= comb_res;
        end
    end

    // R7: a request in stage 1 completes on the next edge.
    assert_vld_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |=> out_vld);

    // R7: no completion appears without a request in stage 1.
    assert_vld_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_vld |=> !out_vld);

    // R8: the result word is held through idle cycles.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_vld |=> $stable(out_res));

    // R6: a zero-count shift passes the operand through.
    assert_shift_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_op == OP_SHR && s1_shamt == '0) |=> (out_res == $past(s1_acc)));

    // R5: an unrounded arithmetic shift keeps the operand's sign.
    assert_shr_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_op == OP_SHR && !s1_rnd) |=> (out_res[DATA_W-1] == $past(s1_acc[DATA_W-1])));

endmodule

// File: rtl/dual_mac_unit.sv
// Module: dual_mac_unit
// Top level: NUM_LANES identical, independent MAC lanes that may all be
// issued in the same cycle. Assumes inputs are stable around the rising
// edge and reset is synchronous and active low.
module dual_mac_unit #(
    parameter  int NUM_LANES = 2,
    parameter  int HALF_W    = 32,
    parameter  int SHAMT_W   = 6,
    parameter  int FRAC_SH   = 31,
    localparam int DATA_W    = 2 * HALF_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_LANES-1:0]              in_vld,
    input  logic [NUM_LANES-1:0][1:0]         in_op,
    input  logic [NUM_LANES-1:0]              in_rnd,
    input  logic [NUM_LANES-1:0][DATA_W-1:0]  in_acc,
    input  logic [NUM_LANES-1:0][DATA_W-1:0]  in_opa,
    input  logic [NUM_LANES-1:0][DATA_W-1:0]  in_opb,
    input  logic [NUM_LANES-1:0][SHAMT_W-1:0] in_shamt,
    output logic [NUM_LANES-1:0]              out_vld,
    output logic [NUM_LANES-1:0][DATA_W-1:0]  out_res
);

    // One lane per index; lanes share only the clock and reset (R9).
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dmac_lane #(
            .HALF_W (HALF_W),
            .SHAMT_W(SHAMT_W),
            .FRAC_SH(FRAC_SH)
        ) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (in_vld[g]),
            .in_op   (in_op[g]),
            .in_rnd  (in_rnd[g]),
            .in_acc  (in_acc[g]),
            .in_opa  (in_opa[g]),
            .in_opb  (in_opb[g]),
            .in_shamt(in_shamt[g]),
            .out_vld (out_vld[g]),
            .out_res (out_res[g])
        );
    end

endmodule

// File: tb/dual_mac_unit_tb_top.sv
// Bench: behavioural reference model with per-lane queues of expected
// completions, compared on every falling clock edge.
module dual_mac_unit_tb_top;

    localparam int NL = 2;
    localparam int DW = 64;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NL-1:0]        in_vld = '0;
    logic [NL-1:0][1:0]   in_op = '0;
    logic [NL-1:0]        in_rnd = '0;
    logic [NL-1:0][DW-1:0] in_acc = '0, in_opa = '0, in_opb = '0;
    logic [NL-1:0][5:0]   in_shamt = '0;
    logic [NL-1:0]        out_vld;
    logic [NL-1:0][DW-1:0] out_res;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit          ev [NL][$];
    logic [63:0] eq [NL][$];
    string       tq [NL][$];
    logic [63:0] last_res [NL];

    always #10 clk = ~clk;

    dual_mac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
        .in_rnd(in_rnd), .in_acc(in_acc), .in_opa(in_opa), .in_opb(in_opb),
        .in_shamt(in_shamt), .out_vld(out_vld), .out_res(out_res)
    );

    function automatic logic [63:0] model(logic [1:0] op, bit rnd, logic [63:0] a,
                                          logic [63:0] b, logic [63:0] c, int sh);
        longint pl, ph, sl, sh2, sa, r;
        logic [63:0] o;
        pl  = longint'($signed(b[31:0]))  * longint'($signed(c[31:0]));
        ph  = longint'($signed(b[63:32])) * longint'($signed(c[63:32]));
        sl  = pl >>> 31;
        sh2 = ph >>> 31;
        o = a;
        case (op)
            2'b00: o = a + sl;
            2'b01: begin
                o[31:0]  = a[31:0]  + sl[31:0];
                o[63:32] = a[63:32] + sh2[31:0];
            end
            2'b10: o = a + pl + ph;
            default: begin
                if (sh != 0) begin
                    sa = a;
                    r = sa >>> sh;
                    if (rnd) r = r + longint'(a[sh-1]);
                    o = r;
                end
            end
        endcase
        return o;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one lane's request for this cycle and queue its expectation.
    task automatic issue(int l, bit v, logic [1:0] op, bit rnd, logic [63:0] a,
                         logic [63:0] b, logic [63:0] c, logic [5:0] sh, string tag);
        string t;
        in_vld[l] = v; in_op[l] = op; in_rnd[l] = rnd;
        in_acc[l] = a; in_opa[l] = b; in_opb[l] = c; in_shamt[l] = sh;
        t = tag;
        if (t == "") begin
            case (op)
                2'b00: t = "R2";
                2'b01: t = "R3";
                2'b10: t = "R4";
                default: t = (sh == 0) ? "R6" : "R5";
            endcase
        end
        ev[l].push_back(v);
        eq[l].push_back(model(op, rnd, a, b, c, int'(sh)));
        tq[l].push_back(t);
    endtask

    task automatic idle(int l);
        issue(l, 1'b0, 2'b00, 1'b0, 64'h0, 64'h0, 64'h0, 6'd0, "R8");
    endtask

    // Advance to the next falling edge and compare both lanes.
    task automatic tick();
        @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            bit v;
            logic [63:0] r;
            string t;
            v = ev[l].pop_front();
            r = eq[l].pop_front();
            t = tq[l].pop_front();
            check("R7 out_vld", {63'h0, out_vld[l]}, {63'h0, v});
            if (v) begin
                check(t, out_res[l], r);
                last_res[l] = r;
            end else begin
                check("R8 hold", out_res[l], last_res[l]);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            check("R1 vld", {63'h0, out_vld[l]}, 64'h0);
            check("R1 res", out_res[l], 64'h0);
            last_res[l] = 64'h0;
            ev[l].push_back(1'b0);
            eq[l].push_back(64'h0);
            tq[l].push_back("R1");
        end
        rst_n = 1'b1;

        // R2: most negative halves, garbage upper halves ignored
        issue(0, 1, 2'b00, 1, 64'h0, 64'hDEAD_BEEF_8000_0000, 64'h1234_5678_8000_0000, 6'd9, "R2");
        // R2: negative product truncates toward minus infinity
        issue(1, 1, 2'b00, 0, 64'd5, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 6'd0, "R2");
        tick();
        // R3: per-half wrap, no carry across halves
        issue(0, 1, 2'b01, 0, 64'hFFFF_FFFF_7FFF_FFFF, 64'h4000_0000_4000_0000,
              64'h4000_0000_4000_0000, 6'd0, "R3");
        // R4: dot product wrapping past the 64-bit limit
        issue(1, 1, 2'b10, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_0000_0002,
              64'h7FFF_FFFF_0000_0003, 6'd0, "R4");
        tick();
        // R6: zero shift count with rounding on
        issue(0, 1, 2'b11, 1, 64'h8000_0000_0000_0001, 64'h0, 64'h0, 6'd0, "R6");
        // R5: -1 rounded by one place gives zero
        issue(1, 1, 2'b11, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 6'd1, "R5");
        tick();
        // R5: most negative by 63 without rounding
        issue(0, 1, 2'b11, 0, 64'h8000_0000_0000_0000, 64'h0, 64'h0, 6'd63, "R5");
        // R5: maximum positive rounded by one place, guard bit needed
        issue(1, 1, 2'b11, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 6'd1, "R5");
        tick();
        // R5: 0x18 >> 4 rounds to 2
        issue(0, 1, 2'b11, 1, 64'h18, 64'h0, 64'h0, 6'd4, "R5");
        idle(1);
        tick();
        idle(0); idle(1);
        tick();
        // R9: different operations on both lanes in one cycle
        issue(0, 1, 2'b10, 0, 64'd100, 64'hFFFF_FFFF_0000_0007, 64'h0000_0003_0000_0005, 6'd0, "R9");
        issue(1, 1, 2'b11, 1, 64'hFFFF_FFFF_FFFF_FF00, 64'h0, 64'h0, 6'd3, "R9");
        tick();

        for (int n = 0; n < 4000; n++) begin
            for (int l = 0; l < NL; l++) begin
                bit v;
                logic [5:0] s;
                v = ($urandom % 4) != 0;
                s = ($urandom % 5 == 0) ? 6'd0 : 6'($urandom);
                issue(l, v, 2'($urandom), 1'($urandom), {$urandom, $urandom},
                      {$urandom, $urandom}, {$urandom, $urandom}, s, "");
            end
            tick();
        end
        idle(0); idle(1);
        tick();
        idle(0); idle(1);
        tick();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule